// File: doc/BRIEF.md
# Threshold-Gated Sensor Logger

This block runs one sensor-logging job each time a sequencer hands it a job descriptor. A job carries a threshold and an optional request to rewind the log pointer. The block switches a sensor converter on, waits for the converter to report a finished conversion, and latches the converted value into a sample register. Converter power is dropped in the cycle that follows the capture.

The captured sample is then compared with the job's threshold. If the sample is at or above the threshold, the block issues one SRAM write. The write uses the current log pointer as its address and the sample as its data, and the pointer then moves up by one. A sample below the threshold causes no write and leaves the pointer alone. Either way, the job ends with a one-cycle completion pulse that also says whether anything was logged. The pointer wraps from its top value back to zero, and it raises a sticky wrap flag when it does.

The job input is a valid/ready stream. A descriptor is taken in the cycle where `job_valid` and `job_ready` are both high. `job_ready` is high only while no job is running, so a sequencer that holds `job_valid` high simply waits. The converter, SRAM and completion signals are plain control lines with no back-pressure. The SRAM must accept a write in the single cycle that `mem_we` is high.

Top module: `sense_log_path`

## Requirements
- R1: After reset, `job_ready` is 1, and `adc_pwr`, `mem_we`, `job_done`, `job_logged` and `wrap_flag` are 0, with `mem_addr` at 0.
- R2: A job is accepted only in a cycle where `job_valid` and `job_ready` are both 1. `job_ready` is 0 from the following cycle until the job's completion pulse has gone. `adc_pwr` is 1 in the cycle after acceptance.
- R3: `adc_pwr` stays 1 until the converter raises `adc_done`, and it is 0 from the cycle after that.
- R4: The value on `adc_data` in the cycle where `adc_done` is seen with power on is the sample. A logged job presents that sample on `mem_wdata` during its write.
- R5: The comparison is unsigned: sample >= threshold (both 10 bits) means log. Logging raises `mem_we` for exactly one cycle, two cycles after the capture cycle, with `mem_addr` equal to the pointer before the job.
- R6: When the sample is below the threshold, `mem_we` stays 0 and the pointer is unchanged. `job_done` then rises two cycles after capture, with `job_logged` at 0.
- R7: After every write, the pointer (`mem_addr`) is one higher than before.
- R8: A job accepted with `job_clr_addr` at 1 sets the pointer to 0 before its write.
- R9: A write at pointer 255 moves the pointer to 0 and sets `wrap_flag`. `wrap_flag` then stays 1 until reset.
- R10: Each job gives exactly one single-cycle `job_done` pulse. For a logged job the pulse comes in the cycle after the write, with `job_logged` at 1.
- R11: `adc_done` while `adc_pwr` is 0 is ignored: no job starts, and no sample is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| job_valid | input | 1 | Job descriptor offered |
| job_ready | output | 1 | Block idle, can take a job |
| job_thresh | input | 10 | Logging threshold of the job |
| job_clr_addr | input | 1 | Rewind log pointer to zero at acceptance |
| adc_pwr | output | 1 | Converter power enable |
| adc_done | input | 1 | Converter conversion finished |
| adc_data | input | 10 | Converter result |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | 8 | SRAM address (log pointer) |
| mem_wdata | output | 10 | SRAM write data |
| job_done | output | 1 | Job completion pulse |
| job_logged | output | 1 | With job_done: sample was written |
| wrap_flag | output | 1 | Sticky pointer wrap indicator |

## Verification
The bench aims at the edges of the comparison: samples equal to the threshold and one below it, plus thresholds of 0 and 1023. A design that compares with strict inequality, or as a signed value, would log or skip the wrong samples. It also drives more than 256 logged jobs, so the pointer goes past 255. A design that saturates the pointer or forgets the sticky flag would show the wrong address after the wrap. Stray converter done pulses while the block is idle check that nothing is captured without power. Checks of power after capture and of the pointer after skipped jobs catch a converter left powered, or a pointer that advances without a write.

// File: rtl/sense_log_pkg.sv
package sense_log_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_CMP,
    ST_STORE,
    ST_FIN
  } job_st_t;
endpackage

// File: rtl/sample_capture.sv
module sample_capture #(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm,
  input  logic                conv_done,
  input  logic [SAMPLE_W-1:0] conv_data,
  output logic                grabbed,
  output logic [SAMPLE_W-1:0] sample
);
  // a done indication only counts while the converter is powered (armed)
  assign grabbed = arm & conv_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sample <= '0;
    else if (grabbed) sample <= conv_data;
  end

  // R11: sample register never moves without an armed done
  assert_no_stray_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> $stable(sample));
endmodule

// File: rtl/threshold_cmp.sv
module threshold_cmp #(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SAMPLE_W-1:0] thr_in,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                pass
);
  logic [SAMPLE_W-1:0] thr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    thr_q <= '0;
    else if (load) thr_q <= thr_in;
  end

  // unsigned at-or-above test
  assign pass = (sample >= thr_q);
endmodule

// File: rtl/addr_advance.sv
module addr_advance #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              wrapped
);
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] next_addr;
  assign next_addr = addr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      wrapped <= 1'b0;
    end else if (clr) begin
      addr <= '0;
    end else if (step) begin
      addr <= next_addr;
      if (addr == TOP) wrapped <= 1'b1;
    end
  end

  // R7: every write advances the pointer by one (modulo the address space)
  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> addr == ADDR_W'($past(addr) + 1'b1));
  // R9: wrap indicator is sticky
  assert_wrap_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped |=> wrapped);
endmodule

// File: rtl/sense_log_path.sv
module sense_log_path
  import sense_log_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                job_valid,
  output logic                job_ready,
  input  logic [SAMPLE_W-1:0] job_thresh,
  input  logic                job_clr_addr,
  output logic                adc_pwr,
  input  logic                adc_done,
  input  logic [SAMPLE_W-1:0] adc_data,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [SAMPLE_W-1:0] mem_wdata,
  output logic                job_done,
  output logic                job_logged,
  output logic                wrap_flag
);
  job_st_t st_q, st_d;
  logic    take, grabbed, pass, logged_q;
  logic [SAMPLE_W-1:0] sample;

  assign job_ready = (st_q == ST_IDLE);
  assign take      = job_valid & job_ready;
  assign adc_pwr   = (st_q == ST_ACQ);
  assign mem_we    = (st_q == ST_STORE);
  assign mem_wdata = sample;
  assign job_done  = (st_q == ST_FIN);
  assign job_logged = job_done & logged_q;

  sample_capture #(.SAMPLE_W(SAMPLE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .arm(adc_pwr), .conv_done(adc_done),
    .conv_data(adc_data), .grabbed(grabbed), .sample(sample)
  );

  threshold_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .load(take), .thr_in(job_thresh),
    .sample(sample), .pass(pass)
  );

  addr_advance #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(take & job_clr_addr), .step(mem_we),
    .addr(mem_addr), .wrapped(wrap_flag)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (take)    st_d = ST_ACQ;
      ST_ACQ:   if (grabbed) st_d = ST_CMP;
      ST_CMP:   st_d = pass ? ST_STORE : ST_FIN;
      ST_STORE: st_d = ST_FIN;
      ST_FIN:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      logged_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (take)        logged_q <= 1'b0;
      else if (mem_we) logged_q <= 1'b1;
    end
  end

  // R3: converter power drops right after the capture
  assert_pwr_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grabbed |=> !adc_pwr);
  // R6: failed comparison never writes
  assert_skip_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CMP && !pass) |=> !mem_we);
  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |=> !job_done);
  // R5: a write lasts one cycle and is followed by completion
  assert_write_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (!mem_we && job_done && job_logged));
  // R2: while ready, nothing else is active
  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    job_ready |-> (!adc_pwr && !mem_we && !job_done));
endmodule

// File: tb/test_sense_log_path.sv
module test_sense_log_path;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       job_valid = 1'b0;
  logic       job_ready;
  logic [9:0] job_thresh = '0;
  logic       job_clr_addr = 1'b0;
  logic       adc_pwr;
  logic       adc_done = 1'b0;
  logic [9:0] adc_data = '0;
  logic       mem_we;
  logic [7:0] mem_addr;
  logic [9:0] mem_wdata;
  logic       job_done, job_logged, wrap_flag;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] exp_addr = '0;
  logic       exp_wrap = 1'b0;

  always #4 clk = ~clk;

  sense_log_path i_sense_log_path (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
    .job_thresh(job_thresh), .job_clr_addr(job_clr_addr), .adc_pwr(adc_pwr),
    .adc_done(adc_done), .adc_data(adc_data), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .job_done(job_done),
    .job_logged(job_logged), .wrap_flag(wrap_flag)
  );

  function automatic logic want_log(logic [9:0] s, logic [9:0] t);
    return s >= t;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic stray_done(input logic [9:0] d);
    @(negedge clk);
    adc_done = 1'b1; adc_data = d;
    @(negedge clk);
    adc_done = 1'b0;
    chk(job_ready == 1'b1, "R11 ready after stray done", int'(job_ready), 1);
    chk(adc_pwr == 1'b0, "R11 power after stray done", int'(adc_pwr), 0);
  endtask

  task automatic run_job(input logic [9:0] thr, input logic clr,
                         input logic [9:0] smp, input int dly);
    logic lg;
    @(negedge clk);
    job_valid = 1'b1; job_thresh = thr; job_clr_addr = clr;
    @(negedge clk);
    job_valid = 1'b0; job_clr_addr = 1'b0; job_thresh = ~thr;
    if (clr) exp_addr = '0;
    chk(adc_pwr == 1'b1, "R2 power after accept", int'(adc_pwr), 1);
    chk(job_ready == 1'b0, "R2 busy after accept", int'(job_ready), 0);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk(adc_pwr == 1'b1, "R3 power held", int'(adc_pwr), 1);
    end
    adc_done = 1'b1; adc_data = smp;
    @(negedge clk);
    adc_done = 1'b0; adc_data = ~smp;
    chk(adc_pwr == 1'b0, "R3 power off after capture", int'(adc_pwr), 0);
    lg = want_log(smp, thr);
    @(negedge clk);
    if (lg) begin
      chk(mem_we == 1'b1, "R5 write", int'(mem_we), 1);
      chk(mem_addr == exp_addr, "R5 write addr", int'(mem_addr), int'(exp_addr));
      chk(mem_wdata == smp, "R4 write data", int'(mem_wdata), int'(smp));
      @(negedge clk);
      if (exp_addr == 8'hFF) exp_wrap = 1'b1;
      exp_addr = exp_addr + 8'd1;
      chk(mem_we == 1'b0, "R5 single write", int'(mem_we), 0);
      chk(job_done && job_logged, "R10 done logged", int'({job_done, job_logged}), 3);
      chk(mem_addr == exp_addr, "R7 pointer advance", int'(mem_addr), int'(exp_addr));
    end else begin
      chk(mem_we == 1'b0, "R6 no write", int'(mem_we), 0);
      chk(job_done && !job_logged, "R6 done not logged", int'({job_done, job_logged}), 2);
      chk(mem_addr == exp_addr, "R6 pointer held", int'(mem_addr), int'(exp_addr));
    end
    @(negedge clk);
    chk(job_done == 1'b0, "R10 done pulse ends", int'(job_done), 0);
    chk(job_ready == 1'b1, "R2 ready again", int'(job_ready), 1);
    chk(wrap_flag == exp_wrap, "R9 wrap flag", int'(wrap_flag), int'(exp_wrap));
  endtask

  initial begin
    void'($urandom(32'd2468));
    #2;
    chk(job_ready == 1'b1 && adc_pwr == 1'b0 && mem_we == 1'b0, "R1 reset outputs",
        int'({job_ready, adc_pwr, mem_we}), 4);
    chk(mem_addr == 8'd0 && wrap_flag == 1'b0 && job_done == 1'b0 && job_logged == 1'b0,
        "R1 reset state", int'(mem_addr), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    stray_done(10'd77);
    // directed comparison edges
    run_job(10'd500, 1'b0, 10'd500, 2);
    run_job(10'd500, 1'b0, 10'd499, 0);
    run_job(10'd0, 1'b0, 10'd0, 1);
    run_job(10'd1023, 1'b0, 10'd1023, 3);
    run_job(10'd1023, 1'b0, 10'd1022, 0);
    run_job(10'd512, 1'b0, 10'd1000, 1);
    run_job(10'd600, 1'b0, 10'd100, 1);
    // R8 rewind
    run_job(10'd10, 1'b1, 10'd20, 1);
    chk(mem_addr == 8'd1, "R8 pointer after rewind job", int'(mem_addr), 1);
    stray_done(10'd900);
    // constrained random, heavy on logging to reach the wrap (R9)
    for (int i = 0; i < 320; i++) begin
      logic [9:0] t, s;
      t = 10'($urandom_range(0, 1023));
      s = ($urandom_range(0, 3) != 0) ? 10'($urandom_range(int'(t), 1023))
                                      : 10'($urandom_range(0, 1023));
      run_job(t, ($urandom_range(0, 99) == 0), s, $urandom_range(0, 4));
    end
    // force a wrap from a known point
    run_job(10'd0, 1'b1, 10'd5, 0);
    for (int i = 0; i < 255; i++) run_job(10'd0, 1'b0, 10'(i), 0);
    chk(wrap_flag == 1'b1, "R9 wrap set", int'(wrap_flag), 1);
    chk(mem_addr == 8'd0, "R9 pointer wrapped", int'(mem_addr), 0);
    run_job(10'd900, 1'b0, 10'd3, 1);
    chk(wrap_flag == 1'b1, "R9 wrap sticky", int'(wrap_flag), 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule